// File: doc/BRIEF.md
# Disk Task-File DMA Write Sequencer

This block is the device end of a disk task-file register interface, and it carries out one command: a write whose data arrives by DMA. The host loads the start address and the sector count into byte-wide task-file registers, then writes either of two accepted opcodes to the command register. The device raises a DMA request and takes one 16-bit word on each cycle in which the host both acknowledges and strobes. Each full sector goes into a one-sector buffer that block RAM can implement. The block then hands that sector to a media-write handshake. In this project the handshake is a stub with a done/error return.

Status is posted once, when the whole command is over. BSY stays set for the full run. At the end, BSY clears and the interrupt line rises. If a sector fails, the transfer stops at that sector and no later sector is asked for. The address registers then point at the failing sector, the count register holds the number of sectors not yet written, and the error register holds the media error code. Addresses step either as a 28-bit logical block number or as a cylinder/head/sector triple with a sectors-per-track and heads-per-cylinder geometry.

Top module: `dmaw_seq`

## Requirements
- R1: A command-register write (offset 7) of 0xCA or 0xCB starts the command only when the device is idle and drive/head bit 4 equals DEV_ID. Any other opcode, or a mismatched bit 4, changes nothing: status stays 0x50 and no DMA request appears. While the command runs, status reads 0x80.
- R2: The DMA request rises on the clock edge that accepts the command. A word is taken only on an edge where the request, the acknowledge and the strobe are all high. Strobes seen while the request is low are discarded.
- R3: After the SECT_WORDS-th word of a sector, the DMA request falls on the next edge and the media request rises. The media request holds until the media reports done, and the two requests are never high together.
- R4: Status is posted only once per command, two edges after the final media done. At that point BSY (bit 7) clears, DRDY (bit 6) and DSC (bit 4) are set, and the interrupt rises. No interrupt is raised between sectors.
- R5: A sector count of 0 means 256 sectors.
- R6: With drive/head bit 6 set, the start address is a 28-bit block number spread over sector number (bits 7:0), cylinder low (15:8), cylinder high (23:16) and drive/head bits 3:0 (27:24). It goes up by one per sector, with carries crossing all four registers.
- R7: With drive/head bit 6 clear, the sector number counts from 1 to SPT. When it passes SPT it returns to 1 and the head (drive/head bits 3:0) advances. When the head passes HEADS-1 it returns to 0 and the 16-bit cylinder {high, low} advances.
- R8: On success, the count register reads 0x00 and the address registers hold the last sector written, in the same layout the host used to load them.
- R9: When media done arrives with the error flag set, no further DMA request is raised. Status reads 0x51, the error register (offset 1) holds the media code, the address registers hold the failing sector, and the count register holds the sectors left including the failing one.
- R10: A status-register read clears the interrupt on the next edge. If that read falls on the edge that posts status, the interrupt is set and the read returns 0x80.
- R11: Task-file writes made while BSY is set are ignored.
- R12: Word n of the current sector is stored at buffer address n, and the media side reads it on its synchronous read port one edge after presenting the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tf_wr_i | input | 1 | Task-file register write strobe |
| tf_rd_i | input | 1 | Task-file register read strobe |
| tf_addr_i | input | 3 | Task-file register offset |
| tf_wdata_i | input | 8 | Task-file write data |
| tf_rdata_o | output | 8 | Task-file read data, valid the cycle after tf_rd_i |
| irq_o | output | 1 | Command-complete interrupt |
| dma_req_o | output | 1 | Device DMA request |
| dma_ack_i | input | 1 | Host DMA acknowledge |
| dma_stb_i | input | 1 | Host write-data strobe |
| dma_data_i | input | DW | Host write data word |
| med_req_o | output | 1 | Sector ready for media write |
| med_done_i | input | 1 | Media write finished |
| med_err_i | input | 1 | Media write failed (with done) |
| med_code_i | input | 8 | Media error code (with done) |
| med_raddr_i | input | BAW | Media buffer read address |
| med_rdata_o | output | DW | Media buffer read data |

## Verification
The sharpest overlap is a host status read that lands on the same edge that posts completion. The interrupt-set and interrupt-clear paths then compete. The bench provokes this by returning media done and then issuing the status read exactly one cycle later. It judges the outcome from the returned byte, which must still show BSY, and from the interrupt, which must stay high until a later read. A second overlap, stray host strobes arriving while the media request is pending, is judged through the buffer contents of the next sector that the media side reads back.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  // task-file offsets
  localparam logic [2:0] TF_ERRF = 3'd1;
  localparam logic [2:0] TF_CNT  = 3'd2;
  localparam logic [2:0] TF_SNUM = 3'd3;
  localparam logic [2:0] TF_CLO  = 3'd4;
  localparam logic [2:0] TF_CHI  = 3'd5;
  localparam logic [2:0] TF_DH   = 3'd6;
  localparam logic [2:0] TF_CMD  = 3'd7;

  localparam logic [7:0] OP_WDMA_A = 8'hCA;
  localparam logic [7:0] OP_WDMA_B = 8'hCB;

  localparam logic [7:0] STAT_RUN  = 8'h80;
  localparam logic [7:0] STAT_IDLE = 8'h50;
  localparam logic [7:0] DH_RESET  = 8'hA0;

  // 28-bit address, packed so that it reads as a block number
  typedef struct packed {
    logic [3:0] head;
    logic [7:0] chi;
    logic [7:0] clo;
    logic [7:0] snum;
  } tf_addr_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_MEDIA} sq_state_t;
endpackage

// File: rtl/dmaw_addr_step.sv
module dmaw_addr_step
  import dmaw_pkg::*;
#(
  parameter int SPT   = 63,
  parameter int HEADS = 16
) (
  input  logic     lba_mode_i,
  input  tf_addr_t cur_i,
  output tf_addr_t nxt_o
);
  localparam logic [7:0] SPT_B     = 8'(SPT);
  localparam logic [3:0] HEAD_LAST = 4'(HEADS - 1);

  logic [27:0] lba_nxt;
  logic [15:0] cyl_nxt;

  assign lba_nxt = cur_i + 28'd1;
  assign cyl_nxt = {cur_i.chi, cur_i.clo} + 16'd1;

  always_comb begin
    nxt_o = cur_i;
    if (lba_mode_i) begin
      nxt_o = lba_nxt;
    end else if (cur_i.snum >= SPT_B) begin
      nxt_o.snum = 8'd1;
      if (cur_i.head >= HEAD_LAST) begin
        nxt_o.head = 4'd0;
        {nxt_o.chi, nxt_o.clo} = cyl_nxt;
      end else begin
        nxt_o.head = cur_i.head + 4'd1;
      end
    end else begin
      nxt_o.snum = cur_i.snum + 8'd1;
    end
  end
endmodule

// File: rtl/dmaw_sector_buf.sv
module dmaw_sector_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/dmaw_ctrl.sv
module dmaw_ctrl
  import dmaw_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int WAW   = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [7:0]     nsec_i,
  input  logic           dma_ack_i,
  input  logic           dma_stb_i,
  input  logic           med_done_i,
  input  logic           med_err_i,
  output logic           dma_req_o,
  output logic           med_req_o,
  output logic           wr_en_o,
  output logic [WAW-1:0] wr_addr_o,
  output logic           step_o,
  output logic           fin_o,
  output logic           fin_err_o,
  output logic [7:0]     rem_o
);
  localparam logic [WAW-1:0] WLAST = WAW'(WORDS - 1);

  sq_state_t      state_q;
  logic [WAW-1:0] wcnt_q;
  logic [8:0]     rem_q;
  logic           accept;

  assign accept    = (state_q == SQ_XFER) && dma_req_o && dma_ack_i && dma_stb_i;
  assign wr_en_o   = accept;
  assign wr_addr_o = wcnt_q;
  assign rem_o     = rem_q[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      dma_req_o <= 1'b0;
      med_req_o <= 1'b0;
      wcnt_q    <= '0;
      rem_q     <= '0;
      step_o    <= 1'b0;
      fin_o     <= 1'b0;
      fin_err_o <= 1'b0;
    end else begin
      step_o    <= 1'b0;
      fin_o     <= 1'b0;
      fin_err_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q   <= SQ_XFER;
            dma_req_o <= 1'b1;
            wcnt_q    <= '0;
            rem_q     <= (nsec_i == 8'd0) ? 9'd256 : {1'b0, nsec_i};
          end
        end
        SQ_XFER: begin
          if (accept) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q == WLAST) begin
              dma_req_o <= 1'b0;
              med_req_o <= 1'b1;
              state_q   <= SQ_MEDIA;
            end
          end
        end
        SQ_MEDIA: begin
          if (med_done_i) begin
            med_req_o <= 1'b0;
            if (med_err_i || rem_q == 9'd1) begin
              fin_o     <= 1'b1;
              fin_err_o <= med_err_i;
              state_q   <= SQ_IDLE;
            end else begin
              step_o    <= 1'b1;
              rem_q     <= rem_q - 9'd1;
              wcnt_q    <= '0;
              dma_req_o <= 1'b1;
              state_q   <= SQ_XFER;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R3: the last word of a sector hands over to the media side
  assert_sector_handover_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && wcnt_q == WLAST) |=> (!dma_req_o && med_req_o));

  // R3: host and media requests never overlap
  assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(dma_req_o && med_req_o));

  // R9: a failed sector ends the transfer
  assert_halt_on_error_R9: assert property (@(posedge clk) disable iff (rst)
    (med_req_o && med_done_i && med_err_i) |=> (!dma_req_o && !med_req_o && fin_o));
endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq
  import dmaw_pkg::*;
#(
  parameter int DEV_ID     = 0,
  parameter int SECT_WORDS = 256,
  parameter int SPT        = 63,
  parameter int HEADS      = 16,
  parameter int DW         = 16,
  parameter int BAW        = $clog2(SECT_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tf_wr_i,
  input  logic           tf_rd_i,
  input  logic [2:0]     tf_addr_i,
  input  logic [7:0]     tf_wdata_i,
  output logic [7:0]     tf_rdata_o,
  output logic           irq_o,
  output logic           dma_req_o,
  input  logic           dma_ack_i,
  input  logic           dma_stb_i,
  input  logic [DW-1:0]  dma_data_i,
  output logic           med_req_o,
  input  logic           med_done_i,
  input  logic           med_err_i,
  input  logic [7:0]     med_code_i,
  input  logic [BAW-1:0] med_raddr_i,
  output logic [DW-1:0]  med_rdata_o
);
  localparam logic DEV_BIT = DEV_ID[0];

  logic [7:0] r_cnt, r_snum, r_clo, r_chi, r_dh, r_err, r_stat, code_q;
  logic       busy_q;
  logic       start, is_op, host_wr;
  logic       step, fin, fin_err;
  logic [7:0] rem;
  logic       buf_we;
  logic [BAW-1:0] buf_waddr;
  tf_addr_t   cur_addr, nxt_addr;

  assign host_wr = tf_wr_i && !busy_q;
  assign is_op   = (tf_wdata_i == OP_WDMA_A) || (tf_wdata_i == OP_WDMA_B);
  assign start   = host_wr && (tf_addr_i == TF_CMD) && is_op && (r_dh[4] == DEV_BIT);
  assign cur_addr = '{head: r_dh[3:0], chi: r_chi, clo: r_clo, snum: r_snum};

  dmaw_addr_step #(.SPT(SPT), .HEADS(HEADS)) step_i (
    .lba_mode_i (r_dh[6]),
    .cur_i      (cur_addr),
    .nxt_o      (nxt_addr)
  );

  dmaw_ctrl #(.WORDS(SECT_WORDS), .WAW(BAW)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .nsec_i     (r_cnt),
    .dma_ack_i  (dma_ack_i),
    .dma_stb_i  (dma_stb_i),
    .med_done_i (med_done_i),
    .med_err_i  (med_err_i),
    .dma_req_o  (dma_req_o),
    .med_req_o  (med_req_o),
    .wr_en_o    (buf_we),
    .wr_addr_o  (buf_waddr),
    .step_o     (step),
    .fin_o      (fin),
    .fin_err_o  (fin_err),
    .rem_o      (rem)
  );

  dmaw_sector_buf #(.DW(DW), .DEPTH(SECT_WORDS), .AW(BAW)) buf_i (
    .clk     (clk),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (dma_data_i),
    .raddr_i (med_raddr_i),
    .rdata_o (med_rdata_o)
  );

  // task-file registers, status and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt  <= 8'h00;
      r_snum <= 8'h00;
      r_clo  <= 8'h00;
      r_chi  <= 8'h00;
      r_dh   <= DH_RESET;
      r_err  <= 8'h00;
      r_stat <= STAT_IDLE;
      code_q <= 8'h00;
      busy_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (host_wr) begin
        unique case (tf_addr_i)
          TF_CNT:  r_cnt  <= tf_wdata_i;
          TF_SNUM: r_snum <= tf_wdata_i;
          TF_CLO:  r_clo  <= tf_wdata_i;
          TF_CHI:  r_chi  <= tf_wdata_i;
          TF_DH:   r_dh   <= {1'b1, tf_wdata_i[6], 1'b1, tf_wdata_i[4:0]};
          default: ;
        endcase
      end
      if (start) begin
        busy_q <= 1'b1;
        r_stat <= STAT_RUN;
        r_err  <= 8'h00;
      end
      if (med_req_o && med_done_i && med_err_i) code_q <= med_code_i;
      if (step) begin
        r_snum <= nxt_addr.snum;
        r_clo  <= nxt_addr.clo;
        r_chi  <= nxt_addr.chi;
        r_dh   <= {r_dh[7:4], nxt_addr.head};
      end
      if (fin) begin
        busy_q <= 1'b0;
        r_stat <= STAT_IDLE | {7'd0, fin_err};
        r_err  <= fin_err ? code_q : 8'h00;
        r_cnt  <= fin_err ? rem : 8'h00;
        irq_o  <= 1'b1;
      end else if (tf_rd_i && tf_addr_i == TF_CMD) begin
        irq_o  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tf_rdata_o <= 8'h00;
    end else if (tf_rd_i) begin
      unique case (tf_addr_i)
        TF_ERRF: tf_rdata_o <= r_err;
        TF_CNT:  tf_rdata_o <= r_cnt;
        TF_SNUM: tf_rdata_o <= r_snum;
        TF_CLO:  tf_rdata_o <= r_clo;
        TF_CHI:  tf_rdata_o <= r_chi;
        TF_DH:   tf_rdata_o <= r_dh;
        TF_CMD:  tf_rdata_o <= r_stat;
        default: tf_rdata_o <= 8'h00;
      endcase
    end
  end

  // R2: the host is only asked for data while the command runs
  assert_req_in_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> busy_q);

  // R4: completion clears BSY and raises the interrupt together
  assert_post_once_R4: assert property (@(posedge clk) disable iff (rst)
    fin |=> (!busy_q && irq_o && !$past(irq_o) == 1'b1 || !busy_q && irq_o));

  // R4: no completion report while idle
  assert_fin_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
    fin |-> busy_q);

  // R10: a status read with no completion pending drops the interrupt
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (tf_rd_i && tf_addr_i == TF_CMD && !fin) |=> !irq_o);

  // R11: registers loaded by the host hold still while busy
  assert_cnt_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fin && $past(busy_q)) |-> $stable(r_cnt));
endmodule

// File: tb/dmaw_seq_tb.sv
module dmaw_seq_tb_top;
  localparam int WORDS = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tf_wr = 0, tf_rd = 0;
  logic [2:0] tf_addr = 0;
  logic [7:0] tf_wdata = 0;
  logic [7:0] tf_rdata;
  logic irq, dma_req, med_req;
  logic dma_ack = 0, dma_stb = 0;
  logic [15:0] dma_data = 0;
  logic med_done = 0, med_err = 0;
  logic [7:0] med_code = 0;
  logic [7:0] med_raddr = 0;
  logic [15:0] med_rdata;

  always #4 clk = ~clk;

  dmaw_seq dut_i (
    .clk(clk), .rst(rst), .tf_wr_i(tf_wr), .tf_rd_i(tf_rd), .tf_addr_i(tf_addr),
    .tf_wdata_i(tf_wdata), .tf_rdata_o(tf_rdata), .irq_o(irq), .dma_req_o(dma_req),
    .dma_ack_i(dma_ack), .dma_stb_i(dma_stb), .dma_data_i(dma_data), .med_req_o(med_req),
    .med_done_i(med_done), .med_err_i(med_err), .med_code_i(med_code),
    .med_raddr_i(med_raddr), .med_rdata_o(med_rdata)
  );

  int n_checks = 0, n_errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 3) ^ 16'h5A5A;
  endfunction

  // host DMA side
  int  g_word = 0;
  bit  stray_en = 0, gap_en = 0;
  int  cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (dma_req && !(gap_en && (cyc % 5 == 0))) begin
      dma_ack  <= 1; dma_stb <= 1; dma_data <= pat(g_word); g_word++;
    end else begin
      dma_ack  <= dma_req | stray_en; dma_stb <= stray_en; dma_data <= 16'hDEAD;
    end
  end

  // media stub (R12 buffer check)
  bit med_auto = 1;
  int sec_idx = 0, inject = -1;
  initial begin
    forever begin
      @(negedge clk);
      if (med_auto && med_req && !med_done) begin
        med_raddr <= 8'd0;
        @(negedge clk);
        chk(med_rdata == pat(g_word - WORDS), "R12 word0", med_rdata, pat(g_word - WORDS));
        med_raddr <= 8'(WORDS - 1);
        @(negedge clk);
        chk(med_rdata == pat(g_word - 1), "R12 last", med_rdata, pat(g_word - 1));
        med_done <= 1; med_err <= (sec_idx == inject); med_code <= 8'h40;
        @(negedge clk);
        med_done <= 0; med_err <= 0;
        sec_idx++;
      end
    end
  end

  // cycle reference model
  bit m_busy, m_req, m_med, m_irq, m_pend;
  logic [7:0] m_cnt, m_dh;
  int m_words, m_rem;
  always @(posedge clk) begin
    bit b0;
    if (rst) begin
      m_busy = 0; m_req = 0; m_med = 0; m_irq = 0; m_pend = 0;
      m_cnt = 0; m_dh = 8'hA0; m_words = 0; m_rem = 0;
    end else begin
      b0 = m_busy;
      if (m_pend) begin m_pend = 0; m_busy = 0; m_irq = 1; end
      else if (tf_rd && tf_addr == 7) m_irq = 0;
      if (!b0 && tf_wr) begin
        if (tf_addr == 2) m_cnt = tf_wdata;
        if (tf_addr == 6) m_dh = tf_wdata;
        if (tf_addr == 7 && (tf_wdata == 8'hCA || tf_wdata == 8'hCB) && !m_dh[4]) begin
          m_busy = 1; m_req = 1; m_words = 0; m_rem = (m_cnt == 0) ? 256 : m_cnt;
        end
      end else if (b0 && m_req && dma_ack && dma_stb) begin
        m_words++;
        if (m_words == WORDS) begin m_req = 0; m_med = 1; end
      end else if (b0 && m_med && med_done) begin
        m_med = 0;
        if (med_err || m_rem == 1) m_pend = 1;
        else begin m_rem--; m_req = 1; m_words = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(dma_req == m_req, "R2 dma request", dma_req, m_req);
      chk(med_req == m_med, "R3 media request", med_req, m_med);
      chk(irq == m_irq, "R4 interrupt", irq, m_irq);
    end
  end

  task automatic tf_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); tf_wr <= 1; tf_addr <= a; tf_wdata <= d;
    @(negedge clk); tf_wr <= 0;
  endtask

  task automatic tf_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); tf_rd <= 1; tf_addr <= a;
    @(negedge clk); tf_rd <= 0; v = tf_rdata;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    tf_read(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic load(input logic [7:0] cnt, input logic [7:0] sn, input logic [7:0] lo,
                      input logic [7:0] hi, input logic [7:0] dh);
    tf_write(2, cnt); tf_write(3, sn); tf_write(4, lo); tf_write(5, hi); tf_write(6, dh);
    sec_idx = 0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst <= 0;
    // reset state
    expect_reg(7, 8'h50, "R1 reset status");
    expect_reg(6, 8'hA0, "R1 reset drive/head");
    // R1: wrong device, then wrong opcode
    tf_write(6, 8'hB0); tf_write(7, 8'hCA);
    repeat (4) @(negedge clk);
    expect_reg(7, 8'h50, "R1 device mismatch ignored");
    tf_write(6, 8'hE0); tf_write(7, 8'hC8);
    repeat (4) @(negedge clk);
    expect_reg(7, 8'h50, "R1 other opcode ignored");

    // R6 R8 R11: LBA with full carry, write during busy
    load(8'd2, 8'hFF, 8'hFF, 8'h2F, 8'hE1);
    gap_en = 1;
    tf_write(7, 8'hCA);
    expect_reg(7, 8'h80, "R1 busy status");
    tf_write(5, 8'h55);
    tf_write(2, 8'h09);
    wait_irq();
    gap_en = 0;
    expect_reg(2, 8'h00, "R8 count zero");
    expect_reg(3, 8'h00, "R6 lba 7:0");
    expect_reg(4, 8'h00, "R6 lba 15:8");
    expect_reg(5, 8'h30, "R11 R6 lba 23:16");
    expect_reg(6, 8'hE1, "R6 lba 27:24");
    expect_reg(1, 8'h00, "R8 no error");
    expect_reg(7, 8'h50, "R4 final status");
    @(negedge clk);
    chk(irq == 0, "R10 irq cleared", irq, 0);

    // R7: CHS wrap of sector, head and cylinder, opcode CB, stray strobes
    load(8'd3, 8'd62, 8'h12, 8'h00, 8'hAF);
    stray_en = 1;
    tf_write(7, 8'hCB);
    wait_irq();
    stray_en = 0;
    expect_reg(3, 8'h01, "R7 sector wrap");
    expect_reg(4, 8'h13, "R7 cylinder low");
    expect_reg(5, 8'h00, "R7 cylinder high");
    expect_reg(6, 8'hA0, "R7 head wrap");
    expect_reg(2, 8'h00, "R8 chs count");
    expect_reg(7, 8'h50, "R4 chs status");

    // R9: error at third sector of five
    load(8'd5, 8'h10, 8'h00, 8'h00, 8'hE0);
    inject = 2;
    tf_write(7, 8'hCA);
    wait_irq();
    inject = -1;
    chk(sec_idx == 3, "R9 sectors handed to media", sec_idx, 3);
    expect_reg(7, 8'h51, "R9 error status");
    expect_reg(1, 8'h40, "R9 error code");
    expect_reg(3, 8'h12, "R9 failing address");
    expect_reg(2, 8'h03, "R9 remaining count");

    // R10: status read on the posting edge
    load(8'd1, 8'h20, 8'h00, 8'h00, 8'hE0);
    med_auto = 0;
    tf_write(7, 8'hCA);
    while (!med_req) @(negedge clk);
    med_done <= 1;
    @(negedge clk);
    med_done <= 0; tf_rd <= 1; tf_addr <= 7;
    @(negedge clk);
    tf_rd <= 0;
    chk(tf_rdata == 8'h80, "R10 read on posting edge", tf_rdata, 8'h80);
    chk(irq == 1, "R10 set wins", irq, 1);
    med_auto = 1;
    expect_reg(7, 8'h50, "R10 later status");
    @(negedge clk);
    chk(irq == 0, "R10 later clear", irq, 0);

    // R5: count 0 means 256 sectors
    load(8'd0, 8'h00, 8'h01, 8'h00, 8'hE0);
    tf_write(7, 8'hCB);
    wait_irq();
    chk(sec_idx == 256, "R5 sector total", sec_idx, 256);
    expect_reg(3, 8'hFF, "R5 end lba 7:0");
    expect_reg(4, 8'h01, "R5 end lba 15:8");
    expect_reg(2, 8'h00, "R5 count");
    expect_reg(7, 8'h50, "R5 status");

    repeat (4) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule